// File: doc/BRIEF.md
# SHA-1 Challenge-Response MAC Engine

This block computes a 160-bit message authentication code with one SHA-1 compression over a 512-bit block. The block is assembled inside the engine from a 64-bit secret, a 64-bit challenge that the host loads one byte at a time, a 64-bit device identifier or an all-ones filler, and a fixed padding pattern. A host loads the challenge, pulses one of two start strobes, waits for `busy` to drop, then pulls the result out one bit per read strobe.

The engine does one round per clock. It keeps the message schedule in a 16-word circular buffer and holds the result in the same five working registers that the rounds use. Each computation clears the challenge register, so every computation needs fresh challenge bytes. A second computation that gets none hashes a zero challenge.

Top module: `sha_mac_engine`

## Requirements
- R1: While `rstN` is low and after its release, `busy`, `done` and `macBit` are 0, and the challenge register holds zero.
- R2: `startNoId` hashes a block of sixteen 32-bit words. Words 0 and 1 are `secret[31:0]` and `secret[63:32]`. Words 2 and 3 are `challenge[31:0]` and `challenge[63:32]`. Words 4 and 5 are all ones. Word k for k = 6 to 15 is `{24'hA5A5A5, 8'(k)}`. The hash uses the standard SHA-1 initial values, round functions, round constants and schedule over 80 rounds, and the initial values are added back at the end.
- R3: `startWithId` uses the same layout as R2, except that words 4 and 5 are `devId[31:0]` and `devId[63:32]`.
- R4: When idle, `macBit` shows bit 0 of result word A, and each cycle with `readReq` high advances one bit. The order is A[0..31], then B, C, D, and E[0..31], for 160 bits. With no read and no start, `macBit` holds its value.
- R5: Each cycle with `chalWe` high moves the challenge down by 8 bits and puts `chalByte` into bits 63:56. After eight writes, the first byte sits in bits 7:0. After fewer writes, the bytes not written stay zero at the bottom.
- R6: Starting a computation clears the challenge register, so a later computation with no writes in between uses a zero challenge.
- R7: `busy` rises in the cycle after a start is accepted and stays high for exactly 81 cycles. `done` is a one-cycle pulse in the first cycle that `busy` is low again.
- R8: Start strobes and `readReq` have no effect while `busy` is high.
- R9: If both start strobes are high together, the with-identifier variant runs.
- R10: Challenge writes made while `busy` is high are kept and used by the next computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secret | input | 64 | Stored secret key |
| devId | input | 64 | Device identifier |
| chalWe | input | 1 | Challenge byte write strobe |
| chalByte | input | 8 | Challenge byte |
| startWithId | input | 1 | Start a computation that includes the identifier |
| startNoId | input | 1 | Start a computation with the all-ones filler |
| readReq | input | 1 | Advance the serial result by one bit |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| macBit | output | 1 | Current serial result bit |

## Verification
The bench compares every result against an independent SHA-1 model. The cases it covers are a zero challenge after clearing, a partial three-byte challenge, simultaneous start strobes, and identifier versus filler. Each case catches its own fault: a swapped word order, a challenge that is not cleared, or the wrong priority between the strobes gives a different 160-bit result. Start and read strobes are injected in the middle of a computation. A design that honoured them would restart, shift out garbage, or stretch `busy` beyond 81 cycles. Challenge bytes written during a computation must still reach the next computation, and a pause in the middle of a readout checks that the serial bit holds still.

// File: rtl/sha_mac_pkg.sv
package sha_mac_pkg;
  localparam int WORD_BITS = 32;
  localparam int NUM_ROUNDS = 80;
  localparam int SCHED_WORDS = 16;
  localparam int IDX_BITS = $clog2(NUM_ROUNDS);
  localparam int BUSY_CYCLES = NUM_ROUNDS + 1;

  typedef logic [WORD_BITS-1:0] word_t;

  localparam word_t IV_A = 32'h67452301;
  localparam word_t IV_B = 32'hEFCDAB89;
  localparam word_t IV_C = 32'h98BADCFE;
  localparam word_t IV_D = 32'h10325476;
  localparam word_t IV_E = 32'hC3D2E1F0;

  typedef struct packed {
    logic load;
    logic round;
    logic finish;
    logic shiftOut;
    logic useId;
    logic [IDX_BITS-1:0] idx;
  } ctl_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_BITS - n));
  endfunction

  function automatic word_t roundF(input logic [IDX_BITS-1:0] t, input word_t b, input word_t c, input word_t d);
    if (t < 20) return (b & c) | (~b & d);
    else if (t < 40) return b ^ c ^ d;
    else if (t < 60) return (b & c) | (b & d) | (c & d);
    else return b ^ c ^ d;
  endfunction

  function automatic word_t roundK(input logic [IDX_BITS-1:0] t);
    if (t < 20) return 32'h5A827999;
    else if (t < 40) return 32'h6ED9EBA1;
    else if (t < 60) return 32'h8F1BBCDC;
    else return 32'hCA62C1D6;
  endfunction
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import sha_mac_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startWithId,
  input  logic startNoId,
  input  logic readReq,
  output ctl_t ctl,
  output logic busy,
  output logic done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;
  localparam logic [IDX_BITS-1:0] LAST_ROUND = IDX_BITS'(NUM_ROUNDS - 1);

  state_t state;
  logic [IDX_BITS-1:0] roundCnt;
  logic startAny;

  assign startAny = startWithId | startNoId;
  assign busy = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE: begin
        if (startAny) begin
          ctl.load = 1'b1;
          ctl.useId = startWithId;
        end else if (readReq) begin
          ctl.shiftOut = 1'b1;
        end
      end
      ST_RUN: begin
        ctl.round = 1'b1;
        ctl.idx = roundCnt;
      end
      ST_FIN: ctl.finish = 1'b1;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      roundCnt <= '0;
      done <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          roundCnt <= '0;
          if (startAny) state <= ST_RUN;
        end
        ST_RUN: begin
          if (roundCnt == LAST_ROUND) state <= ST_FIN;
          else roundCnt <= roundCnt + 1'b1;
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import sha_mac_pkg::*;
#(
  parameter logic [23:0] PAD_TAG = 24'hA5A5A5,
  parameter int KEY_BITS = 64
)(
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  logic [KEY_BITS-1:0] secret,
  input  logic [KEY_BITS-1:0] devId,
  input  logic chalWe,
  input  logic [7:0] chalByte,
  output logic macBit
);
  localparam int KEY_WORDS = KEY_BITS / WORD_BITS;
  localparam int CHAL_BASE = KEY_WORDS;
  localparam int ID_BASE = 2 * KEY_WORDS;
  localparam int PAD_BASE = 3 * KEY_WORDS;

  logic [KEY_BITS-1:0] chalReg;
  word_t wBuf [SCHED_WORDS];
  word_t msg [SCHED_WORDS];
  word_t a, b, c, d, e;
  word_t wt, tmp;
  logic [3:0] i4;
  logic [5*WORD_BITS-1:0] cat;

  genvar k;
  generate
    for (k = 0; k < SCHED_WORDS; k++) begin : g_msg
      if (k < CHAL_BASE) begin : g_sec
        assign msg[k] = secret[WORD_BITS*k +: WORD_BITS];
      end else if (k < ID_BASE) begin : g_chal
        assign msg[k] = chalReg[WORD_BITS*(k-CHAL_BASE) +: WORD_BITS];
      end else if (k < PAD_BASE) begin : g_id
        assign msg[k] = ctl.useId ? devId[WORD_BITS*(k-ID_BASE) +: WORD_BITS] : '1;
      end else begin : g_pad
        assign msg[k] = {PAD_TAG, 8'(k)};
      end
    end
  endgenerate

  always_comb begin
    i4 = ctl.idx[3:0];
    if (ctl.idx < IDX_BITS'(SCHED_WORDS))
      wt = wBuf[i4];
    else
      wt = rotl(wBuf[i4 - 4'd3] ^ wBuf[i4 - 4'd8] ^ wBuf[i4 - 4'd14] ^ wBuf[i4], 1);
    tmp = rotl(a, 5) + roundF(ctl.idx, b, c, d) + wt + roundK(ctl.idx) + e;
    cat = {e, d, c, b, a};
  end

  assign macBit = a[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chalReg <= '0;
      for (int j = 0; j < SCHED_WORDS; j++) wBuf[j] <= '0;
      {e, d, c, b, a} <= '0;
    end else begin
      if (ctl.load) chalReg <= '0;
      else if (chalWe) chalReg <= {chalByte, chalReg[KEY_BITS-1:8]};

      if (ctl.load) begin
        for (int j = 0; j < SCHED_WORDS; j++) wBuf[j] <= msg[j];
        a <= IV_A; b <= IV_B; c <= IV_C; d <= IV_D; e <= IV_E;
      end else if (ctl.round) begin
        wBuf[i4] <= wt;
        e <= d;
        d <= c;
        c <= rotl(b, 30);
        b <= a;
        a <= tmp;
      end else if (ctl.finish) begin
        a <= a + IV_A; b <= b + IV_B; c <= c + IV_C; d <= d + IV_D; e <= e + IV_E;
      end else if (ctl.shiftOut) begin
        {e, d, c, b, a} <= {1'b0, cat[5*WORD_BITS-1:1]};
      end
    end
  end
endmodule

// File: rtl/sha_mac_engine.sv
module sha_mac_engine
  import sha_mac_pkg::*;
#(
  parameter logic [23:0] PAD_TAG = 24'hA5A5A5
)(
  input  logic clk,
  input  logic rstN,
  input  logic [63:0] secret,
  input  logic [63:0] devId,
  input  logic chalWe,
  input  logic [7:0] chalByte,
  input  logic startWithId,
  input  logic startNoId,
  input  logic readReq,
  output logic busy,
  output logic done,
  output logic macBit
);
  ctl_t ctl;

  mac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startWithId(startWithId), .startNoId(startNoId),
    .readReq(readReq), .ctl(ctl), .busy(busy), .done(done)
  );

  mac_datapath #(.PAD_TAG(PAD_TAG), .KEY_BITS(64)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .secret(secret), .devId(devId),
    .chalWe(chalWe), .chalByte(chalByte), .macBit(macBit)
  );
endmodule

// File: rtl/sha_mac_chk.sv
module sha_mac_chk
  import sha_mac_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic startWithId,
  input logic startNoId,
  input logic readReq,
  input logic busy,
  input logic done,
  input logic macBit
);
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN) (!busy && (startWithId || startNoId)) |=> busy); // R7
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> (busyRun == BUSY_CYCLES)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN) done |-> (!busy && $past(busy))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN) (!busy && !readReq && !startWithId && !startNoId) |=> $stable(macBit)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (!busy && !done)); // R1
endmodule

bind sha_mac_engine sha_mac_chk u_chk (
  .clk(clk), .rstN(rstN), .startWithId(startWithId), .startNoId(startNoId),
  .readReq(readReq), .busy(busy), .done(done), .macBit(macBit)
);

// File: tb/sha_mac_engine_test.sv
module sha_mac_engine_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, chalWe, startWithId, startNoId, rdMon, rdDrv, readReq;
  logic [63:0] secret, devId;
  logic [7:0] chalByte;
  logic busy, done, macBit;

  assign readReq = rdMon | rdDrv;

  sha_mac_engine uut (
    .clk(clk), .rstN(rstN), .secret(secret), .devId(devId), .chalWe(chalWe),
    .chalByte(chalByte), .startWithId(startWithId), .startNoId(startNoId),
    .readReq(readReq), .busy(busy), .done(done), .macBit(macBit)
  );

  int total = 0, bad = 0, issued = 0, checked = 0;
  logic [159:0] expQ[$];
  string tagQ[$];
  logic [63:0] chalShadow = '0;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] refMac(input logic [63:0] sec, input logic [63:0] ch,
                                          input logic [63:0] id, input bit withId);
    logic [31:0] w [0:79];
    logic [31:0] h0, h1, h2, h3, h4, ra, rb, rc, rd, re, f, kk, t;
    h0 = 32'h67452301; h1 = 32'hEFCDAB89; h2 = 32'h98BADCFE; h3 = 32'h10325476; h4 = 32'hC3D2E1F0;
    w[0] = sec[31:0]; w[1] = sec[63:32];
    w[2] = ch[31:0];  w[3] = ch[63:32];
    w[4] = withId ? id[31:0] : 32'hFFFFFFFF;
    w[5] = withId ? id[63:32] : 32'hFFFFFFFF;
    for (int i = 6; i < 16; i++) w[i] = {24'hA5A5A5, 8'(i)};
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    ra = h0; rb = h1; rc = h2; rd = h3; re = h4;
    for (int i = 0; i < 80; i++) begin
      if (i < 20) begin f = (rb & rc) | (~rb & rd); kk = 32'h5A827999; end
      else if (i < 40) begin f = rb ^ rc ^ rd; kk = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (rb & rc) | (rb & rd) | (rc & rd); kk = 32'h8F1BBCDC; end
      else begin f = rb ^ rc ^ rd; kk = 32'hCA62C1D6; end
      t = rl(ra, 5) + f + w[i] + kk + re;
      re = rd; rd = rc; rc = rl(rb, 30); rb = ra; ra = t;
    end
    return {re + h4, rd + h3, rc + h2, rb + h1, ra + h0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeBytes(input int n, input logic [63:0] v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chalWe = 1'b1;
      chalByte = v[8*i +: 8];
      chalShadow = {v[8*i +: 8], chalShadow[63:8]};
    end
    @(negedge clk);
    chalWe = 1'b0;
  endtask

  task automatic runJob(input string req, input bit sw, input bit sn, input bit injStart,
                        input bit injRead, input bit injChal, input logic [63:0] nextChal);
    int cnt;
    expQ.push_back(refMac(secret, chalShadow, devId, sw));
    tagQ.push_back(req);
    issued++;
    chalShadow = '0;
    @(negedge clk);
    startWithId = sw; startNoId = sn;
    @(negedge clk);
    startWithId = 1'b0; startNoId = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      startNoId = injStart && (cnt == 10);
      startWithId = injStart && (cnt == 30);
      rdDrv = injRead && (cnt >= 12) && (cnt < 16);
      if (injChal && cnt >= 20 && cnt < 28) begin
        chalWe = 1'b1;
        chalByte = nextChal[8*(cnt-20) +: 8];
      end else chalWe = 1'b0;
      @(negedge clk);
    end
    startNoId = 1'b0; startWithId = 1'b0; rdDrv = 1'b0; chalWe = 1'b0;
    if (injChal) chalShadow = nextChal;
    chk(cnt == 81, "R7", "busy length", 160'(cnt), 160'd81);
    chk(done == 1'b1, "R7", "done at busy drop", 160'(done), 160'd1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done single cycle", 160'(done), 160'd0);
    wait (checked == issued);
  endtask

  // scoreboard monitor: pops expected results and streams out the serial MAC
  initial begin
    logic [159:0] got, exp;
    logic held;
    string tag;
    rdMon = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        for (int i = 0; i < 160; i++) begin
          if (i == 80) begin
            rdMon = 1'b0;
            held = macBit;
            repeat (5) @(negedge clk);
            chk(macBit == held, "R4", "bit held while idle", 160'(macBit), 160'(held));
          end
          got[i] = macBit;
          rdMon = 1'b1;
          @(negedge clk);
        end
        rdMon = 1'b0;
        chk(got == exp, tag, "serial MAC", got, exp);
        checked++;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; chalWe = 1'b0; chalByte = '0; startWithId = 1'b0; startNoId = 1'b0; rdDrv = 1'b0;
    secret = 64'h0F1E2D3C4B5A6978;
    devId  = 64'hC1000012345678A4;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !macBit, "R1", "reset outputs", {busy, done, macBit}, 160'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !macBit, "R1", "after release", {busy, done, macBit}, 160'd0);

    writeBytes(8, 64'h1122334455667788);
    runJob("R2_R5", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    writeBytes(8, 64'hDEADBEEFCAFEF00D);
    runJob("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);

    runJob("R6", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    writeBytes(3, 64'h0000000000ABCDEF);
    runJob("R5_partial", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    writeBytes(8, 64'h0123456789ABCDEF);
    runJob("R9", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    writeBytes(8, 64'hA1B2C3D4E5F60718);
    runJob("R8", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0);

    writeBytes(8, 64'h5555AAAA3333CCCC);
    runJob("R10_first", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h90817263544536FF);
    runJob("R10", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule